// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master side of a serial bus that runs on one shared open-drain line, held high by a pull-up resistor when nobody drives it. The block never drives the line high. Its only line output is a drive-low enable, and the line level comes back in as a sampled input that passes through a synchronizer. A transaction opens with a long low reset pulse. Slaves on the bus answer it by pulling the line low for a short while, and the block records that answer as a presence flag. After that, the host moves command and data bytes one bit per time slot.

The host side accepts three operations: bus reset, write byte and read byte. The host presents an operation with a valid strobe while the block is not busy. The block then raises busy and runs the whole sequence. When the sequence ends, it drops busy and gives a one-cycle done pulse in the same cycle. Slot widths, sample points and reset windows are all counted in microseconds. A tick counter that divides the system clock by a parameter produces those microseconds. The gap between two operations can be as long as the host likes, because the line is always released while the block is idle.

Top module: `swm_master`

## Requirements
- R1: After the synchronous reset `rst`, the outputs are `line_pull`=0, `busy`=0, `done`=0, `presence`=0 and `rd_data`=0.
- R2: A bus reset operation (`cmd_op`=2'b01) holds `line_pull` high for exactly RST_LOW_US×CLK_PER_US clock cycles, with 480 µs as the default length.
- R3: A bus reset operation samples the line 70 µs after it releases the line. `presence` becomes 1 if the line is low at that point and 0 if it is high. Write and read operations leave `presence` unchanged.
- R4: Busy rises in the cycle after an operation is accepted and stays high until done. Done lasts one cycle and coincides with busy falling. A bus reset takes (480+70+410)×CLK_PER_US cycles from acceptance to done. A byte operation takes 8×70×CLK_PER_US cycles.
- R5: A write byte operation (`cmd_op`=2'b10) sends `cmd_data` least-significant bit first. A 1 bit is a low pulse of 6 µs. A 0 bit is a low pulse of 60 µs.
- R6: Each bit slot lasts 70 µs from one falling edge of the line to the next. The line is released for at least 10 µs between two slots.
- R7: A read byte operation (`cmd_op`=2'b11) pulls the line low for 6 µs in each slot and samples it 15 µs after the slot starts. Bits are assembled least-significant bit first, and the byte appears on `rd_data` in the cycle of the done pulse.
- R8: An operation presented while busy is ignored, and so is `cmd_op`=2'b00. Neither one starts a sequence, changes the byte in progress, or moves busy or the line.
- R9: `line_pull` is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Operation strobe, taken only while not busy |
| cmd_op | input | 2 | 00 none, 01 bus reset, 10 write byte, 11 read byte |
| cmd_data | input | 8 | Byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| presence | output | 1 | A slave answered the last bus reset |
| rd_data | output | 8 | Byte assembled by the last read |
| line_pull | output | 1 | Drive-low enable for the open-drain line |
| line_in | input | 1 | Level sensed on the line |

## Verification
Faults in the microsecond counter or the phase counter show up at the ports as wrong low-pulse widths or slot periods on `line_pull`. Those are visible within the first slot or the first reset pulse, to the exact clock cycle. A shift register or bit index that has gone wrong shows up as a write bit out of order, or as a wrong `rd_data` when done pulses. A stuck phase shows up as busy that never falls, or as a done pulse that comes at the wrong time. The bench measures every low pulse and every high gap on the line in cycles, and models slaves that answer resets and read slots.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_PRES_WAIT,
    ST_PRES_REST,
    ST_SLOT
  } state_e;
endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_one
      logic r_q;
      always_ff @(posedge clk) begin
        if (rst) r_q <= 1'b1;
        else     r_q <= d;
      end
      assign q = r_q;
    end else begin : g_chain
      logic [STAGES-1:0] ch_q;
      always_ff @(posedge clk) begin
        if (rst) ch_q <= '1;
        else     ch_q <= {ch_q[STAGES-2:0], d};
      end
      assign q = ch_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/swm_us_tick.sv
module swm_us_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/swm_shifter.sv
module swm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         in_bit,
  output logic [W-1:0] q,
  output logic         lsb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (load)  sh_q <= load_val;
    else if (shift) sh_q <= {in_bit, sh_q[W-1:1]};
  end

  assign q   = sh_q;
  assign lsb = sh_q[0];
endmodule

// File: rtl/swm_master.sv
module swm_master #(
  parameter int CLK_PER_US   = 50,
  parameter int BITS         = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_LOW_US   = 480,
  parameter int PRES_WAIT_US = 70,
  parameter int PRES_REST_US = 410,
  parameter int W1_LOW_US    = 6,
  parameter int W0_LOW_US    = 60,
  parameter int REC_US       = 10,
  parameter int RD_LOW_US    = 6,
  parameter int RD_SAMP_US   = 9,
  parameter int RD_TAIL_US   = 55
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [BITS-1:0] cmd_data,
  output logic            busy,
  output logic            done,
  output logic            presence,
  output logic [BITS-1:0] rd_data,
  output logic            line_pull,
  input  logic            line_in
);
  import swm_pkg::*;

  localparam int WR_SLOT_US = W0_LOW_US + REC_US;
  localparam int RD_SLOT_US = RD_LOW_US + RD_SAMP_US + RD_TAIL_US;
  localparam int MAX_A = (RST_LOW_US > PRES_REST_US) ? RST_LOW_US : PRES_REST_US;
  localparam int MAX_B = (WR_SLOT_US > RD_SLOT_US) ? WR_SLOT_US : RD_SLOT_US;
  localparam int MAX_C = (PRES_WAIT_US > MAX_B) ? PRES_WAIT_US : MAX_B;
  localparam int US_MAX = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int US_W  = $clog2(US_MAX + 1);
  localparam int BIT_W = (BITS > 1) ? $clog2(BITS) : 1;

  localparam logic [US_W-1:0] RST_LAST  = US_W'(RST_LOW_US - 1);
  localparam logic [US_W-1:0] PW_LAST   = US_W'(PRES_WAIT_US - 1);
  localparam logic [US_W-1:0] PR_LAST   = US_W'(PRES_REST_US - 1);
  localparam logic [US_W-1:0] WR_LAST   = US_W'(WR_SLOT_US - 1);
  localparam logic [US_W-1:0] RD_LAST   = US_W'(RD_SLOT_US - 1);
  localparam logic [US_W-1:0] RD_SMP    = US_W'(RD_LOW_US + RD_SAMP_US - 1);
  localparam logic [US_W-1:0] W1_LEN    = US_W'(W1_LOW_US);
  localparam logic [US_W-1:0] W0_LEN    = US_W'(W0_LOW_US);
  localparam logic [US_W-1:0] RD_LEN    = US_W'(RD_LOW_US);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);

  state_e            state_q;
  op_e               op_q;
  logic [US_W-1:0]   us_q;
  logic [BIT_W-1:0]  bit_q;
  logic              busy_q, done_q, pres_q, pull_q;
  logic [BITS-1:0]   rd_q;

  logic              tick, line_s, accept, pull_c;
  logic              slot_end, rd_sample, sh_shift, sh_lsb;
  logic [BITS-1:0]   sh_q;
  op_e               op_in;

  assign op_in  = op_e'(cmd_op);
  assign accept = cmd_valid && !busy_q && (op_in != OP_NONE);

  swm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (line_in), .q (line_s)
  );

  swm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk (clk), .rst (rst), .clr (accept), .tick (tick)
  );

  assign slot_end  = (state_q == ST_SLOT) && tick &&
                     (us_q == ((op_q == OP_READ) ? RD_LAST : WR_LAST));
  assign rd_sample = (state_q == ST_SLOT) && (op_q == OP_READ) && tick &&
                     (us_q == RD_SMP);
  assign sh_shift  = rd_sample || (slot_end && (op_q == OP_WRITE));

  swm_shifter #(.W(BITS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (cmd_data),
    .shift    (sh_shift),
    .in_bit   (line_s),
    .q        (sh_q),
    .lsb      (sh_lsb)
  );

  // Line drive for the current phase; registered into pull_q
  always_comb begin
    pull_c = 1'b0;
    case (state_q)
      ST_RST_LOW: pull_c = 1'b1;
      ST_SLOT: begin
        if (op_q == OP_READ) pull_c = (us_q < RD_LEN);
        else                 pull_c = (us_q < (sh_lsb ? W1_LEN : W0_LEN));
      end
      default: pull_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      us_q    <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pres_q  <= 1'b0;
      pull_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      pull_q <= pull_c;
      if (tick && busy_q) us_q <= us_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= (op_in == OP_RESET) ? ST_RST_LOW : ST_SLOT;
            op_q    <= op_in;
            us_q    <= '0;
            bit_q   <= '0;
            busy_q  <= 1'b1;
            if (op_in == OP_RESET) pres_q <= 1'b0;
          end
        end
        ST_RST_LOW: begin
          if (tick && us_q == RST_LAST) begin
            state_q <= ST_PRES_WAIT;
            us_q    <= '0;
          end
        end
        ST_PRES_WAIT: begin
          if (tick && us_q == PW_LAST) begin
            pres_q  <= !line_s;
            state_q <= ST_PRES_REST;
            us_q    <= '0;
          end
        end
        ST_PRES_REST: begin
          if (tick && us_q == PR_LAST) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        ST_SLOT: begin
          if (slot_end) begin
            us_q <= '0;
            if (bit_q == BIT_LAST) begin
              state_q <= ST_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              if (op_q == OP_READ) rd_q <= sh_q;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign presence  = pres_q;
  assign rd_data   = rd_q;
  assign line_pull = pull_q;

  // Checker state: length of the current low drive
  localparam int MAX_LOW = RST_LOW_US * CLK_PER_US;
  localparam int LR_W    = $clog2(MAX_LOW + 2);
  logic [LR_W-1:0] low_run_q;
  always_ff @(posedge clk) begin
    if (rst || !pull_q)                low_run_q <= '0;
    else if (low_run_q != LR_W'(MAX_LOW + 1)) low_run_q <= low_run_q + 1'b1;
  end

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !pull_q);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);
  // R8
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cmd_valid) |=> $stable(op_q));
  // R2
  rst_len_chk: assert property (@(posedge clk) disable iff (rst)
    pull_q |-> (low_run_q < LR_W'(MAX_LOW)));
endmodule

// File: tb/swm_master_bench.sv
module swm_master_bench;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic       busy, done, presence, line_pull, line_in;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;

  // Bench-side bus model
  logic       slave_present = 1'b0;
  logic       slave_pull = 1'b0;
  logic [7:0] slave_byte = 8'h00;
  logic       slave_rd_mode = 1'b0;
  int         rd_bit = 0;
  int         pres_cnt = 0;
  int         rd_hold = 0;
  logic       prev_pull = 1'b0;
  int         run = 0;
  int         nl = 0;
  int         ng = 0;
  int         low_len [0:15];
  int         gap_len [0:15];

  assign line_in = !(line_pull || slave_pull);

  always #5 clk = !clk;

  swm_master #(.CLK_PER_US(CPU)) u_swm_master (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .cmd_data (cmd_data), .busy (busy), .done (done), .presence (presence),
    .rd_data (rd_data), .line_pull (line_pull), .line_in (line_in)
  );

  always @(negedge clk) begin
    if (prev_pull && !line_pull) begin
      if (nl < 16) low_len[nl] = run;
      nl = nl + 1;
      if (run >= 480 * CPU && slave_present) pres_cnt = 1;
      run = 1;
    end else if (!prev_pull && line_pull) begin
      if (nl > 0 && ng < 16) begin gap_len[ng] = run; ng = ng + 1; end
      if (slave_rd_mode) begin
        if (!slave_byte[rd_bit % 8]) rd_hold = 30 * CPU;
        rd_bit = rd_bit + 1;
      end
      run = 1;
    end else begin
      run = run + 1;
    end
    prev_pull = line_pull;
    if (pres_cnt > 0) pres_cnt = pres_cnt + 1;
    if (pres_cnt > 140 * CPU) pres_cnt = 0;
    if (rd_hold > 0) rd_hold = rd_hold - 1;
    slave_pull = (pres_cnt > 20 * CPU) || (rd_hold > 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one operation and return cycles from acceptance to done
  task automatic run_op(input logic [1:0] op, input logic [7:0] data,
                        input bit poke_busy, output int cyc);
    int n;
    bit busy_ok;
    nl = 0; ng = 0; rd_bit = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    n = 1;
    busy_ok = 1'b1;
    while (!done && n < 20000) begin
      if (!busy) busy_ok = 1'b0;
      if (poke_busy && n == 50) begin
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_data = ~data;
      end
      if (poke_busy && n == 52) begin
        cmd_valid = 1'b0; cmd_op = 2'b00;
      end
      @(negedge clk);
      n = n + 1;
    end
    cyc = n - 1;
    check(busy_ok, "R4 busy held", busy_ok, 1);
    check(done && !busy, "R4 done with busy low", busy, 0);
    @(negedge clk);
    check(!done, "R4 done one cycle", done, 0);
    check(!line_pull, "R9 line released when idle", line_pull, 0);
  endtask

  task automatic t_reset_state();
    check(line_pull == 1'b0, "R1 line_pull", line_pull, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(presence == 1'b0, "R1 presence", presence, 0);
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
  endtask

  task automatic t_nop();
    bit quiet = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (busy || line_pull) quiet = 1'b0;
    end
    cmd_valid = 1'b0;
    check(quiet, "R8 op 00 ignored", quiet, 1);
  endtask

  task automatic t_bus_reset(input bit present);
    int cyc;
    slave_present = present;
    run_op(2'b01, 8'h00, 1'b0, cyc);
    check(nl == 1, "R2 one reset pulse", nl, 1);
    check(low_len[0] == 480 * CPU, "R2 reset pulse width", low_len[0], 480 * CPU);
    check(cyc == 960 * CPU, "R4 reset duration", cyc, 960 * CPU);
    check(presence == present, "R3 presence flag", presence, present);
  endtask

  task automatic t_write(input logic [7:0] val, input bit poke);
    int cyc;
    bit prev_pres;
    prev_pres = presence;
    run_op(2'b10, val, poke, cyc);
    check(cyc == 560 * CPU, "R4 byte duration", cyc, 560 * CPU);
    check(nl == 8, "R5 eight slots", nl, 8);
    for (int i = 0; i < 8; i++) begin
      int exp_w = val[i] ? 6 * CPU : 60 * CPU;
      check(low_len[i] == exp_w, poke ? "R8 byte unchanged" : "R5 bit width",
            low_len[i], exp_w);
    end
    for (int i = 0; i < 7; i++) begin
      check(low_len[i] + gap_len[i] == 70 * CPU, "R6 slot period",
            low_len[i] + gap_len[i], 70 * CPU);
      check(gap_len[i] >= 10 * CPU, "R6 recovery", gap_len[i], 10 * CPU);
    end
    check(presence == prev_pres, "R3 presence kept by write", presence, prev_pres);
  endtask

  task automatic t_read(input logic [7:0] val);
    int cyc;
    slave_byte = val;
    slave_rd_mode = 1'b1;
    run_op(2'b11, 8'h00, 1'b0, cyc);
    slave_rd_mode = 1'b0;
    check(cyc == 560 * CPU, "R4 read duration", cyc, 560 * CPU);
    check(nl == 8, "R7 eight slots", nl, 8);
    for (int i = 0; i < 8; i++)
      check(low_len[i] == 6 * CPU, "R7 read pulse width", low_len[i], 6 * CPU);
    check(rd_data == val, "R7 read byte", rd_data, val);
  endtask

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_nop();
    t_bus_reset(1'b1);
    t_write(8'hA5, 1'b0);
    t_read(8'h5A);
    t_read(8'h81);
    t_write(8'h3C, 1'b1);
    t_bus_reset(1'b0);
    t_write(8'hFF, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule